// File: doc/BRIEF.md
# Card Sector Read Sequencer

This block is a bus master that fetches a run of sectors from a memory-card controller. The controller exposes 16-bit registers over a simple request/acknowledge register bus, and the fetched data leaves this block as a byte stream. A single start pulse carries a 28-bit starting block address and a sector count. From there the sequencer works on its own: it takes the controller lock, checks that a card is present, and waits for the controller to accept a command. It then programs the transfer one chunk of up to 256 sectors at a time and empties the controller's data buffer in 16-word bursts.

Every 16-bit data word goes out as two bytes on a valid/ready stream, low byte first. The run ends with a one-cycle `done` pulse. An error flag may come with it: one for a missing card, one for a lock or readiness wait that ran out of retries. On every exit path the sequencer releases the controller lock before it reports.

Top module: `sector_fetch_seq`

## Requirements
- R1: After reset `busy`, `done`, `bus_req` and `byte_valid` are all low.
- R2: Locking reads the control register (address 0x18), writes it back with bit 1 set, then reads the status register (address 0x04) until bit 1 is set. After `LOCK_TRIES` status reads with bit 1 clear and the card present, the run ends with `err_timeout`.
- R3: A status read with bit 4 (card present) clear, during the lock wait or the readiness wait, ends the run with `err_absent`, after the lock is released. No bytes are emitted.
- R4: Once locked, status is read until bit 8 (ready for command) is set. After `RDY_TRIES` reads without it, the lock is released and the run ends with `err_timeout`.
- R5: The request is split into chunks of min(remaining, 256) sectors. After each chunk the block address advances by the chunk size modulo 2^28.
- R6: Each chunk writes the address bits [15:0] to 0x10 and then {4'b0, address bits [27:16]} to 0x12.
- R7: Each chunk then writes 0x0300 | (chunk size mod 256) to 0x14, so a full 256-sector chunk writes 0x0300.
- R8: After the count write, control bit 7 is set by a read followed by a write. It stays set through every data read of the chunk and is cleared by a read and a write after the last one.
- R9: Each 16-word burst from the data port (0x40) waits for a status read with bit 5 set. A chunk reads exactly `SECTOR_WORDS` words per sector.
- R10: Each data word leaves as two bytes, bits [7:0] first. `byte_data` holds steady while `byte_valid` is high and `byte_ready` is low.
- R11: A successful run clears control bit 1 by a read and a write, with every other control bit kept. It then pulses `done` for one cycle with both error flags low. A count of 0 gives `done` with no bus access.
- R12: `bus_req` stays high with `bus_addr`, `bus_we` and `bus_wdata` unchanged until `bus_ack`. Only one access is in flight at a time.
- R13: `err_absent` and `err_timeout` are never high together, and each is high only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a run when the sequencer is idle |
| start_lba | input | 28 | First block address of the run |
| sector_count | input | COUNT_W | Number of sectors to read |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_absent | output | 1 | With `done`: card not present |
| err_timeout | output | 1 | With `done`: lock or ready wait exhausted |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 7 | Register byte address |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | 16 | Read data |
| byte_data | output | 8 | Output byte |
| byte_valid | output | 1 | Output byte is valid |
| byte_ready | input | 1 | Consumer accepts the byte |

## Verification
The hardest cases to reach from the ports are the retry exhaustion paths and the 256-sector chunk boundary. The bench's register model therefore takes, for each run, a number of status polls before it grants the lock and a number before it reports ready. A value larger than the retry limit makes the wait run out with the card still present. A separate knob removes the card. The bench counts the status reads to confirm the limits. Runs of 257 sectors, with the sector size shrunk by parameter, cross the chunk boundary at an address just below a 16-bit carry. That checks the zero encoding of a full chunk and the upper-address write in a single run.

// File: rtl/sfs_pkg.sv
// Shared constants and the state type of the card sector read sequencer.
// Assumes a controller with 16-bit registers addressed by byte offset.
package sfs_pkg;
    localparam logic [6:0]  A_STATUS = 7'h04;
    localparam logic [6:0]  A_LBA_LO = 7'h10;
    localparam logic [6:0]  A_LBA_HI = 7'h12;
    localparam logic [6:0]  A_COUNT  = 7'h14;
    localparam logic [6:0]  A_CTRL   = 7'h18;
    localparam logic [6:0]  A_DATA   = 7'h40;

    localparam int ST_LOCK  = 1;
    localparam int ST_CARD  = 4;
    localparam int ST_BUF   = 5;
    localparam int ST_READY = 8;

    localparam logic [15:0] M_LOCK   = 16'h0002;
    localparam logic [15:0] M_CFGRST = 16'h0080;
    localparam logic [7:0]  CMD_READ = 8'h03;

    localparam int CHUNK_MAX   = 256;
    localparam int BURST_WORDS = 16;
    localparam int LBA_W       = 28;

    typedef enum logic [4:0] {
        S_IDLE, S_LK_RD, S_LK_WR, S_LK_POLL, S_LK_GAP,
        S_RY_POLL, S_RY_GAP, S_LBA_LO, S_LBA_HI, S_CNT,
        S_RS_RD, S_RS_WR, S_BUF_POLL, S_DAT_RD, S_DRAIN,
        S_RC_RD, S_RC_WR, S_RL_RD, S_RL_WR, S_FIN
    } seq_state_t;

    typedef enum logic [1:0] { OUT_OK, OUT_ABSENT, OUT_TIMEOUT } outcome_t;
endpackage

// File: rtl/sfs_chunk_pick.sv
// Picks the size of the next chunk from the sectors still to read and forms
// the sector-count register word. Assumes COUNT_W >= 9.
module sfs_chunk_pick
    import sfs_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic [COUNT_W-1:0] remaining,
    output logic [8:0]         chunk,
    output logic [15:0]        code
);
    // Cap the chunk at the controller limit; a full chunk encodes as 0.
    always_comb begin
        if (remaining > COUNT_W'(CHUNK_MAX)) chunk = 9'(CHUNK_MAX);
        else                                 chunk = remaining[8:0];
        code = {CMD_READ, chunk[7:0]};
    end
endmodule

// File: rtl/sfs_word_to_bytes.sv
// Holds one 16-bit word and hands it out as two bytes, low byte first,
// on a valid/ready stream. Assumes load only arrives while not busy.
module sfs_word_to_bytes (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] word,
    output logic        busy,
    output logic [7:0]  byte_data,
    output logic        byte_valid,
    input  logic        byte_ready
);
    logic [15:0] hold_q;
    logic [1:0]  pend_q;   // 0 empty, 1 low byte due, 2 high byte due

    // Capture a word and step through its two bytes as they are taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            pend_q <= 2'd0;
        end else if (load) begin
            hold_q <= word;
            pend_q <= 2'd1;
        end else if (byte_valid && byte_ready) begin
            pend_q <= (pend_q == 2'd1) ? 2'd2 : 2'd0;
        end
    end

    // Present the due byte.
    always_comb begin
        busy       = (pend_q != 2'd0);
        byte_valid = busy;
        byte_data  = (pend_q == 2'd2) ? hold_q[15:8] : hold_q[7:0];
    end

    // R10
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));
    // R10
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);
endmodule

// File: rtl/sector_fetch_seq.sv
// Bus-master sequencer that reads a run of sectors from a card controller's
// register interface and streams them out as bytes. Assumes one register
// access at a time, read data valid with ack, and SECTOR_WORDS a multiple of 16.
module sector_fetch_seq
    import sfs_pkg::*;
#(
    parameter int COUNT_W      = 16,
    parameter int SECTOR_WORDS = 256,
    parameter int LOCK_TRIES   = 10,
    parameter int LOCK_GAP     = 64,
    parameter int RDY_TRIES    = 2000,
    parameter int RDY_GAP      = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [27:0]        start_lba,
    input  logic [COUNT_W-1:0] sector_count,
    output logic               busy,
    output logic               done,
    output logic               err_absent,
    output logic               err_timeout,
    output logic               bus_req,
    output logic               bus_we,
    output logic [6:0]         bus_addr,
    output logic [15:0]        bus_wdata,
    input  logic               bus_ack,
    input  logic [15:0]        bus_rdata,
    output logic [7:0]         byte_data,
    output logic               byte_valid,
    input  logic               byte_ready
);
    localparam int TRY_MAX = (LOCK_TRIES > RDY_TRIES) ? LOCK_TRIES : RDY_TRIES;
    localparam int GAP_MAX = (LOCK_GAP > RDY_GAP) ? LOCK_GAP : RDY_GAP;
    localparam int TRY_W   = $clog2(TRY_MAX + 1);
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int WL_W    = $clog2(CHUNK_MAX * SECTOR_WORDS + 1);

    seq_state_t         state;
    outcome_t           outcome;
    logic [LBA_W-1:0]   lba_q;
    logic [COUNT_W-1:0] remain_q;
    logic [15:0]        ctrl_q;
    logic [TRY_W-1:0]   tries_q;
    logic [GAP_W-1:0]   gap_q;
    logic [WL_W-1:0]    words_left;
    logic [8:0]         chunk;
    logic [15:0]        cnt_code;
    logic               split_busy;
    logic               split_load;

    sfs_chunk_pick #(.COUNT_W(COUNT_W)) u_pick (
        .remaining (remain_q),
        .chunk     (chunk),
        .code      (cnt_code)
    );

    assign split_load = (state == S_DAT_RD) && bus_ack;

    sfs_word_to_bytes u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (split_load),
        .word       (bus_rdata),
        .busy       (split_busy),
        .byte_data  (byte_data),
        .byte_valid (byte_valid),
        .byte_ready (byte_ready)
    );

    // Sequence the lock, polls, chunk programming, buffer drain and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            outcome    <= OUT_OK;
            lba_q      <= '0;
            remain_q   <= '0;
            ctrl_q     <= '0;
            tries_q    <= '0;
            gap_q      <= '0;
            words_left <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    lba_q    <= start_lba;
                    remain_q <= sector_count;
                    outcome  <= OUT_OK;
                    tries_q  <= '0;
                    state    <= (sector_count == '0) ? S_FIN : S_LK_RD;
                end
                S_LK_RD: if (bus_ack) begin
                    ctrl_q <= bus_rdata;
                    state  <= S_LK_WR;
                end
                S_LK_WR: if (bus_ack) state <= S_LK_POLL;
                S_LK_POLL: if (bus_ack) begin
                    if (bus_rdata[ST_LOCK]) begin
                        tries_q <= '0;
                        state   <= S_RY_POLL;
                    end else if (!bus_rdata[ST_CARD]) begin
                        outcome <= OUT_ABSENT;
                        state   <= S_RL_RD;
                    end else if (tries_q == TRY_W'(LOCK_TRIES - 1)) begin
                        outcome <= OUT_TIMEOUT;
                        state   <= S_RL_RD;
                    end else begin
                        tries_q <= tries_q + 1'b1;
                        gap_q   <= '0;
                        state   <= S_LK_GAP;
                    end
                end
                S_LK_GAP: begin
                    if (gap_q == GAP_W'(LOCK_GAP - 1)) state <= S_LK_POLL;
                    else gap_q <= gap_q + 1'b1;
                end
                S_RY_POLL: if (bus_ack) begin
                    if (!bus_rdata[ST_CARD]) begin
                        outcome <= OUT_ABSENT;
                        state   <= S_RL_RD;
                    end else if (bus_rdata[ST_READY]) begin
                        state <= S_LBA_LO;
                    end else if (tries_q == TRY_W'(RDY_TRIES - 1)) begin
                        outcome <= OUT_TIMEOUT;
                        state   <= S_RL_RD;
                    end else begin
                        tries_q <= tries_q + 1'b1;
                        gap_q   <= '0;
                        state   <= S_RY_GAP;
                    end
                end
                S_RY_GAP: begin
                    if (gap_q == GAP_W'(RDY_GAP - 1)) state <= S_RY_POLL;
                    else gap_q <= gap_q + 1'b1;
                end
                S_LBA_LO: if (bus_ack) state <= S_LBA_HI;
                S_LBA_HI: if (bus_ack) state <= S_CNT;
                S_CNT:    if (bus_ack) state <= S_RS_RD;
                S_RS_RD: if (bus_ack) begin
                    ctrl_q     <= bus_rdata;
                    words_left <= WL_W'(chunk * SECTOR_WORDS);
                    state      <= S_RS_WR;
                end
                S_RS_WR:    if (bus_ack) state <= S_BUF_POLL;
                S_BUF_POLL: if (bus_ack && bus_rdata[ST_BUF]) state <= S_DAT_RD;
                S_DAT_RD: if (bus_ack) begin
                    words_left <= words_left - 1'b1;
                    state      <= S_DRAIN;
                end
                S_DRAIN: if (!split_busy) begin
                    if (words_left == '0)                          state <= S_RC_RD;
                    else if (words_left[3:0] == 4'd0)              state <= S_BUF_POLL;
                    else                                           state <= S_DAT_RD;
                end
                S_RC_RD: if (bus_ack) begin
                    ctrl_q <= bus_rdata;
                    state  <= S_RC_WR;
                end
                S_RC_WR: if (bus_ack) begin
                    lba_q    <= lba_q + LBA_W'(chunk);
                    remain_q <= remain_q - COUNT_W'(chunk);
                    state    <= (remain_q == COUNT_W'(chunk)) ? S_RL_RD : S_LBA_LO;
                end
                S_RL_RD: if (bus_ack) begin
                    ctrl_q <= bus_rdata;
                    state  <= S_RL_WR;
                end
                S_RL_WR: if (bus_ack) state <= S_FIN;
                S_FIN:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the register access that belongs to the current state.
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = A_STATUS;
        bus_wdata = '0;
        unique case (state)
            S_LK_RD, S_RS_RD, S_RC_RD, S_RL_RD: bus_addr = A_CTRL;
            S_LK_WR: begin bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = ctrl_q | M_LOCK;    end
            S_RS_WR: begin bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = ctrl_q | M_CFGRST;  end
            S_RC_WR: begin bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = ctrl_q & ~M_CFGRST; end
            S_RL_WR: begin bus_we = 1'b1; bus_addr = A_CTRL; bus_wdata = ctrl_q & ~M_LOCK;   end
            S_LK_POLL, S_RY_POLL, S_BUF_POLL: bus_addr = A_STATUS;
            S_LBA_LO: begin bus_we = 1'b1; bus_addr = A_LBA_LO; bus_wdata = lba_q[15:0]; end
            S_LBA_HI: begin bus_we = 1'b1; bus_addr = A_LBA_HI; bus_wdata = {4'b0, lba_q[27:16]}; end
            S_CNT:    begin bus_we = 1'b1; bus_addr = A_COUNT;  bus_wdata = cnt_code; end
            S_DAT_RD: bus_addr = A_DATA;
            default:  bus_req = 1'b0;
        endcase
    end

    // Report the run state and the outcome pulse.
    always_comb begin
        busy        = (state != S_IDLE) && (state != S_FIN);
        done        = (state == S_FIN);
        err_absent  = done && (outcome == OUT_ABSENT);
        err_timeout = done && (outcome == OUT_TIMEOUT);
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));
    // R6
    hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == A_LBA_HI |-> bus_wdata[15:12] == 4'b0);
    // R7
    cnt_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == A_COUNT |-> bus_wdata[15:8] == CMD_READ);
    // R5
    chunk_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        remain_q != '0 |-> chunk != 9'd0 && chunk <= 9'(CHUNK_MAX));
    // R13
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_absent || err_timeout) |-> done && !(err_absent && err_timeout));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sector_fetch_seq_tb.sv
module sector_fetch_seq_tb;
    localparam int SW  = 16;
    localparam int LT  = 6;
    localparam int RT  = 5;
    localparam logic [15:0] CTRL_INIT = 16'h0C41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [27:0] start_lba = '0;
    logic [15:0] sector_count = '0;
    logic        busy, done, err_absent, err_timeout;
    logic        bus_req, bus_we, bus_ack;
    logic [6:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic [7:0]  byte_data;
    logic        byte_valid;
    logic        byte_ready = 1'b0;

    always #5 clk = ~clk;

    sector_fetch_seq #(.COUNT_W(16), .SECTOR_WORDS(SW), .LOCK_TRIES(LT), .LOCK_GAP(4),
                       .RDY_TRIES(RT), .RDY_GAP(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_lba(start_lba),
        .sector_count(sector_count), .busy(busy), .done(done),
        .err_absent(err_absent), .err_timeout(err_timeout),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready));

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mkword(input logic [27:0] sec, input int widx);
        logic [7:0] w8;
        w8 = 8'(widx);
        return {sec[15:8] + w8, sec[7:0] ^ sec[23:16] ^ w8 ^ 8'h5A};
    endfunction

    function automatic logic [7:0] exp_byte(input logic [27:0] lba, input int n);
        logic [27:0] sec;
        logic [15:0] w;
        sec = lba + 28'(n / (2 * SW));
        w   = mkword(sec, (n % (2 * SW)) / 2);
        return (n % 2 == 0) ? w[7:0] : w[15:8];
    endfunction

    // Case knobs written only by the stimulus process.
    logic [27:0] case_lba = '0;
    int  case_cnt = 0;
    bit  present = 1'b1;
    int  lock_delay = 0, rdy_delay = 0, buf_delay = 0;
    bit  m_clear = 1'b0;

    // Register model state, written only by the model process.
    logic [15:0] ctrl = CTRL_INIT;
    logic [27:0] cur_lba = '0;
    int lk_polls = 0, ry_polls = 0, stat_reads = 0, acc_cnt = 0;
    int wcnt = 0, burst_pos = 0, buf_t = 0, chunk_idx = 0, cur_chunk = 0, lat = 0;
    bit prev_pend = 1'b0;
    logic [6:0] prev_addr = '0;

    // Behavioural card controller register model.
    always @(posedge clk) begin
        bit granted, rdy, bufr;
        int rem, ech;
        logic [27:0] elba;
        bus_ack <= 1'b0;
        if (m_clear) begin
            ctrl <= CTRL_INIT; lk_polls <= 0; ry_polls <= 0; stat_reads <= 0;
            acc_cnt <= 0; wcnt <= 0; burst_pos <= 0; buf_t <= 0; chunk_idx <= 0;
            cur_chunk <= 0; lat <= 0; prev_pend <= 1'b0;
        end else begin
            if (prev_pend)
                chk(bus_req && bus_addr == prev_addr, "R12", "request held until ack",
                    bus_addr, prev_addr);
            prev_pend <= bus_req && !bus_ack;
            prev_addr <= bus_addr;
            if (ctrl[7] && buf_t < 1000) buf_t <= buf_t + 1;
            granted = ctrl[1] && (lk_polls >= lock_delay);
            rdy     = granted && present && (ry_polls >= rdy_delay);
            bufr    = ctrl[7] && (buf_t >= buf_delay);
            rem     = case_cnt - chunk_idx * 256;
            ech     = (rem > 256) ? 256 : rem;
            elba    = case_lba + 28'(chunk_idx * 256);
            if (bus_req && !bus_ack) begin
                if (lat != 0) lat <= lat - 1;
                else begin
                    bus_ack <= 1'b1;
                    lat     <= int'($urandom % 3);
                    acc_cnt <= acc_cnt + 1;
                    if (bus_we) begin
                        case (bus_addr)
                            7'h18: begin
                                if (bus_wdata[7] && !ctrl[7]) begin buf_t <= 0; burst_pos <= 0; end
                                if (!bus_wdata[7] && ctrl[7])
                                    chk(wcnt == cur_chunk * SW, "R9", "words read per chunk",
                                        wcnt, cur_chunk * SW);
                                ctrl <= bus_wdata;
                            end
                            7'h10: begin
                                chk(bus_wdata == elba[15:0], "R6", "low address write",
                                    bus_wdata, elba[15:0]);
                                cur_lba[15:0] <= bus_wdata;
                            end
                            7'h12: begin
                                chk(bus_wdata == {4'b0, elba[27:16]}, "R6", "high address write",
                                    bus_wdata, {4'b0, elba[27:16]});
                                cur_lba[27:16] <= bus_wdata[11:0];
                            end
                            7'h14: begin
                                chk(bus_wdata == (16'h0300 | 16'(ech & 8'hFF)), "R7",
                                    "count write", bus_wdata, 16'h0300 | 16'(ech & 8'hFF));
                                chk(ctrl[1] && !ctrl[7], "R8", "count written locked, reset clear",
                                    ctrl, 16'h0002);
                                chunk_idx <= chunk_idx + 1;
                                cur_chunk <= ech;
                                wcnt      <= 0;
                            end
                            default: chk(1'b0, "R12", "write to unknown address", bus_addr, 0);
                        endcase
                    end else begin
                        case (bus_addr)
                            7'h18: bus_rdata <= ctrl;
                            7'h04: begin
                                stat_reads <= stat_reads + 1;
                                if (ctrl[1] && !granted) lk_polls <= lk_polls + 1;
                                if (granted && !rdy) ry_polls <= ry_polls + 1;
                                bus_rdata <= {7'b0, rdy, 2'b0, bufr, present, 2'b0, granted, 1'b0};
                            end
                            7'h40: begin
                                chk(bufr, "R9", "data read only when buffer ready", bufr, 1);
                                chk(ctrl[7] && ctrl[1], "R8", "reset and lock held during data read",
                                    ctrl, 16'h0082);
                                bus_rdata <= mkword(cur_lba + 28'(wcnt / SW), wcnt % SW);
                                wcnt <= wcnt + 1;
                                if (burst_pos == 15) begin burst_pos <= 0; buf_t <= 0; end
                                else burst_pos <= burst_pos + 1;
                            end
                            default: begin
                                chk(1'b0, "R12", "read of unknown address", bus_addr, 0);
                                bus_rdata <= '0;
                            end
                        endcase
                    end
                end
            end
        end
    end

    // Byte sink with random backpressure, and capture of the end-of-run pulse.
    int  nbytes = 0;
    bit  got_done = 1'b0, got_abs = 1'b0, got_tmo = 1'b0;
    logic [7:0] last_byte = '0;
    bit last_stall = 1'b0;
    always @(negedge clk) begin
        bit rd;
        if (m_clear) begin
            nbytes = 0; got_done = 1'b0; got_abs = 1'b0; got_tmo = 1'b0; last_stall = 1'b0;
            byte_ready = 1'b0;
        end else begin
            if (last_stall)
                chk(byte_valid && byte_data == last_byte, "R10", "byte held under backpressure",
                    byte_data, last_byte);
            rd = ($urandom % 4) != 0;
            byte_ready = rd;
            last_stall = byte_valid && !rd;
            last_byte  = byte_data;
            if (byte_valid && rd) begin
                chk(byte_data == exp_byte(case_lba, nbytes), "R10", "stream byte (R5 address order)",
                    byte_data, exp_byte(case_lba, nbytes));
                nbytes++;
            end
            if (done) begin
                got_done = 1'b1;
                got_abs  = err_absent;
                got_tmo  = err_timeout;
                chk(!(err_absent && err_timeout), "R13", "single error flag",
                    {err_absent, err_timeout}, 0);
            end
        end
    end

    task automatic run_case(input logic [27:0] lba, input int cnt, input bit pres,
                            input int lkd, input int ryd, input int bufd, input int expect_out);
        @(negedge clk); #1;
        case_lba = lba; case_cnt = cnt; present = pres;
        lock_delay = lkd; rdy_delay = ryd; buf_delay = bufd;
        m_clear = 1'b1;
        repeat (2) @(negedge clk);
        #1 m_clear = 1'b0;
        start_lba = lba; sector_count = 16'(cnt); start = 1'b1;
        @(negedge clk); #1 start = 1'b0;
        while (!got_done) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(!busy, "R11", "idle after done", busy, 0);
        chk(got_abs == (expect_out == 1), "R3", "absent flag", got_abs, expect_out == 1);
        chk(got_tmo == (expect_out == 2), "R4", "timeout flag", got_tmo, expect_out == 2);
        chk(nbytes == ((expect_out == 0) ? cnt * 2 * SW : 0), "R5", "bytes delivered",
            nbytes, (expect_out == 0) ? cnt * 2 * SW : 0);
        chk(ctrl == CTRL_INIT, "R11", "lock and reset released, other bits kept", ctrl, CTRL_INIT);
        if (cnt == 0) chk(acc_cnt == 0, "R11", "zero count makes no access", acc_cnt, 0);
        if (expect_out == 0)
            chk(chunk_idx == (cnt + 255) / 256, "R5", "chunk count", chunk_idx, (cnt + 255) / 256);
        if (expect_out == 2 && lkd > LT)
            chk(stat_reads == LT, "R2", "lock polls before timeout", stat_reads, LT);
        if (expect_out == 2 && lkd <= LT)
            chk(stat_reads == lkd + 1 + RT, "R4", "ready polls before timeout",
                stat_reads, lkd + 1 + RT);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (195000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not finish, actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_req && !byte_valid, "R1", "reset state",
            {busy, done, bus_req, byte_valid}, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !bus_req && !byte_valid, "R1", "idle after reset",
            {busy, done, bus_req, byte_valid}, 0);
        // R11: single sector and zero count
        run_case(28'h0000123, 1, 1'b1, 0, 0, 2, 0);
        run_case(28'h0000200, 0, 1'b1, 0, 0, 0, 0);
        // R5 R6 R7: 257 sectors crossing a 16-bit carry, full chunk encodes as 0
        run_case(28'h00FFF80, 257, 1'b1, 1, 2, 1, 0);
        // R3: card absent
        run_case(28'h0000010, 4, 1'b0, 0, 0, 0, 1);
        // R2: lock never granted
        run_case(28'h0000020, 4, 1'b1, 1000, 0, 0, 2);
        // R4: ready never reported
        run_case(28'h0000030, 4, 1'b1, 2, 1000, 0, 2);
        // R9 R10: random runs with random delays and addresses near the top
        for (int i = 0; i < 6; i++)
            run_case(28'($urandom) | ((i == 0) ? 28'hFFFFFF0 : 28'h0),
                     1 + int'($urandom % 12), 1'b1, int'($urandom % 3),
                     int'($urandom % 4), int'($urandom % 6), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule